// File: doc/BRIEF.md
# Load-Linked Decode and Reservation Unit

This unit accepts a 32-bit extended compact instruction, made of a 16-bit prefix halfword in bits [31:16] and a 16-bit instruction halfword in bits [15:0]. It recognises the load-linked word form and pulls out the split 9-bit offset and the two 3-bit register fields. It then forms the effective address from a base register value and checks that the address is word aligned.

For an aligned address, the unit issues one word read on a request/acknowledge memory port. When the read completes, it writes the loaded word to the destination register and arms the processor's single reservation with the address. A misaligned address raises an address-error pulse instead.

The reservation can be dropped by an external clear, for example on exception return or when a snooped write hits the reserved word. A store-conditional query port reports whether the reservation still holds for a given address. Every query consumes the reservation.

Top module: `ll_resv_unit`

## Requirements
- R1: A word is accepted as load-linked only if all of these fields hold: bits [31:27]=11110, bits [26:25]=00, bits [20:19]=00, bits [15:11]=10010 and bits [7:5]=110. Any other word presented with instr_valid causes no memory request, no address error and no write-back.
- R2: The 3-bit register codes map to 5-bit registers: code 0 maps to 16, code 1 maps to 17, and codes 2 to 7 map to themselves. The base code is bits [18:16] and drives base_idx combinationally. The destination code is bits [10:8].
- R3: The offset is {bits[24:21], bits[4:0]}, a 9-bit two's-complement value. mem_addr equals base_val plus the sign-extended offset.
- R4: If either of the two low effective-address bits is nonzero, addr_err is high for exactly the one cycle after acceptance. In that case there is no memory request and no write-back, and the link flag and link address are unchanged.
- R5: mem_req rises in the cycle after acceptance and stays high with mem_addr stable until the cycle in which mem_ack is high. instr_ready is low for that whole time.
- R6: wb_en is high in the same cycle as mem_ack while a read is pending. In that cycle wb_data equals mem_rdata and wb_idx is the mapped destination register.
- R7: In the cycle after the acknowledge, link_flag is 1 and link_addr holds the effective address. A later load-linked replaces the earlier address.
- R8: link_clr clears link_flag at the next edge. If an arm and a clear occur in the same cycle, the arm wins.
- R9: sc_ok is high, combinationally, when sc_query is high, link_flag is set and sc_addr equals link_addr. Any query clears link_flag at the next edge unless an arm happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is present |
| instr_word | input | 32 | Prefix halfword in [31:16], instruction halfword in [15:0] |
| instr_ready | output | 1 | Unit is idle and can accept a word |
| base_idx | output | 5 | Mapped base register index for the register file read |
| base_val | input | 32 | Value of the base register |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Read address, held until acknowledge |
| mem_ack | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Read data |
| wb_en | output | 1 | Destination register write enable |
| wb_idx | output | 5 | Mapped destination register index |
| wb_data | output | 32 | Data to write |
| addr_err | output | 1 | Address-error exception pulse |
| link_clr | input | 1 | External reservation clear |
| sc_query | input | 1 | Store-conditional query strobe |
| sc_addr | input | 32 | Store-conditional address |
| sc_ok | output | 1 | Query succeeds |
| link_flag | output | 1 | Reservation is armed |
| link_addr | output | 32 | Reserved address |

## Verification
The unit has results on three different cycles after a stimulus:

- The same cycle: base_idx, and wb_en, wb_idx, wb_data and sc_ok, all of which are combinational from their inputs.
- One edge after acceptance: mem_req, mem_addr and addr_err.
- One edge after the acknowledge, clear or query: link_flag and link_addr.

The bench drives every input on the falling edge and waits a short delay before checking same-cycle outputs. It checks registered outputs on the falling edge after the edge that loads them. An added wait before the acknowledge checks that the request stays held.

// File: rtl/ll_pkg.sv
`timescale 1ns/1ps
package ll_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int FLD_W  = 3;
    localparam int OFF_W  = 9;

    localparam logic [4:0] PFX_CODE = 5'b11110;
    localparam logic [4:0] MAJ_CODE = 5'b10010;
    localparam logic [2:0] SEL_CODE = 3'd6;

    typedef struct packed {
        logic              busy;
        logic [XLEN-1:0]   addr;
        logic [RIDX_W-1:0] dst;
        logic              err;
    } ctl_t;

    typedef struct packed {
        logic            flag;
        logic [XLEN-1:0] addr;
    } link_t;

    function automatic logic [RIDX_W-1:0] map_reg(input logic [FLD_W-1:0] c);
        if (c == 3'd0)      return 5'd16;
        else if (c == 3'd1) return 5'd17;
        else                return {2'b00, c};
    endfunction
endpackage

// File: rtl/ll_decode.sv
`timescale 1ns/1ps
module ll_decode
    import ll_pkg::*;
(
    input  logic [31:0]       word,
    output logic              hit,
    output logic [RIDX_W-1:0] dst_idx,
    output logic [RIDX_W-1:0] bas_idx,
    output logic [OFF_W-1:0]  off9
);
    always_comb begin
        hit = (word[31:27] == PFX_CODE) && (word[26:25] == 2'b00) &&
              (word[20:19] == 2'b00)    && (word[15:11] == MAJ_CODE) &&
              (word[7:5] == SEL_CODE);
        dst_idx = map_reg(word[10:8]);
        bas_idx = map_reg(word[18:16]);
        off9    = {word[24:21], word[4:0]};
    end
endmodule

// File: rtl/ll_agen.sv
`timescale 1ns/1ps
module ll_agen
    import ll_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic [AW-1:0]    base,
    input  logic [OFF_W-1:0] off9,
    output logic [AW-1:0]    ea,
    output logic             misal
);
    localparam int EXT_W = AW - OFF_W;
    always_comb begin
        ea    = base + {{EXT_W{off9[OFF_W-1]}}, off9};
        misal = |ea[1:0];
    end
endmodule

// File: rtl/ll_link.sv
`timescale 1ns/1ps
module ll_link
    import ll_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [XLEN-1:0] arm_addr,
    input  logic            clr,
    input  logic            query,
    input  logic [XLEN-1:0] query_addr,
    output logic            flag,
    output logic [XLEN-1:0] addr,
    output logic            ok
);
    link_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (clr || query) lk_d.flag = 1'b0;
        if (arm) begin
            lk_d.flag = 1'b1;
            lk_d.addr = arm_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign flag = lk_q.flag;
    assign addr = lk_q.addr;
    assign ok   = query && lk_q.flag && (query_addr == lk_q.addr);

    // R7: an arm leaves the flag set with the armed address
    a_r7_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (flag && addr == $past(arm_addr)));
    // R8/R9: a clear or query without an arm drops the flag
    a_r9_query_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr || query) && !arm) |=> !flag);
    // R9: success requires an armed flag
    a_r9_ok_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (flag && query));
endmodule

// File: rtl/ll_resv_unit.sv
`timescale 1ns/1ps
module ll_resv_unit
    import ll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              instr_ready,
    output logic [RIDX_W-1:0] base_idx,
    input  logic [XLEN-1:0]   base_val,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              addr_err,
    input  logic              link_clr,
    input  logic              sc_query,
    input  logic [XLEN-1:0]   sc_addr,
    output logic              sc_ok,
    output logic              link_flag,
    output logic [XLEN-1:0]   link_addr
);
    logic              dec_hit;
    logic [RIDX_W-1:0] dec_dst;
    logic [OFF_W-1:0]  dec_off;
    logic [XLEN-1:0]   ea;
    logic              misal;
    logic              take, done;
    ctl_t              c_d, c_q;

    ll_decode u_dec (
        .word    (instr_word),
        .hit     (dec_hit),
        .dst_idx (dec_dst),
        .bas_idx (base_idx),
        .off9    (dec_off)
    );

    ll_agen #(.AW(XLEN)) u_agen (
        .base  (base_val),
        .off9  (dec_off),
        .ea    (ea),
        .misal (misal)
    );

    assign take = instr_valid && !c_q.busy && dec_hit;
    assign done = c_q.busy && mem_ack;

    always_comb begin
        c_d     = c_q;
        c_d.err = 1'b0;
        if (take) begin
            if (misal) begin
                c_d.err = 1'b1;
            end else begin
                c_d.busy = 1'b1;
                c_d.addr = ea;
                c_d.dst  = dec_dst;
            end
        end else if (done) begin
            c_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign instr_ready = !c_q.busy;
    assign mem_req     = c_q.busy;
    assign mem_addr    = c_q.addr;
    assign addr_err    = c_q.err;
    assign wb_en       = done;
    assign wb_idx      = c_q.dst;
    assign wb_data     = mem_rdata;

    ll_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (done),
        .arm_addr   (c_q.addr),
        .clr        (link_clr),
        .query      (sc_query),
        .query_addr (sc_addr),
        .flag       (link_flag),
        .addr       (link_addr),
        .ok         (sc_ok)
    );

    // R4: an address error never comes with a request or write-back
    a_r4_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!mem_req && !wb_en));
    // R4: error is a single-cycle pulse
    a_r4_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_err && !(instr_valid && dec_hit && misal)) |=> !addr_err);
    // R5: request and address held until acknowledge
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R6: write-back only while a read is pending
    a_r6_wb_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (mem_req && mem_ack));
    // R1: a non-matching word leaves the unit idle
    a_r1_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !dec_hit && !mem_req) |=> (!mem_req && !addr_err));
endmodule

// File: tb/sim_ll_resv_unit.sv
`timescale 1ns/1ps
module sim_ll_resv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        instr_ready;
    logic [4:0]  base_idx;
    logic [31:0] base_val = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        addr_err;
    logic        link_clr = 1'b0;
    logic        sc_query = 1'b0;
    logic [31:0] sc_addr = '0;
    logic        sc_ok;
    logic        link_flag;
    logic [31:0] link_addr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ll_resv_unit u0 (.*);

    function automatic logic [31:0] enc(input logic [2:0] rx, input logic [2:0] rb,
                                        input logic [8:0] imm);
        return {5'b11110, 2'b00, imm[8:5], 2'b00, rb, 5'b10010, rx, 3'd6, imm[4:0]};
    endfunction

    function automatic logic [4:0] mapr(input logic [2:0] c);
        return (c == 3'd0) ? 5'd16 : (c == 3'd1) ? 5'd17 : {2'b00, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // rx, rb, imm9, base, rdata
    localparam int NV = 5;
    localparam logic [2:0]  V_RX [NV] = '{3'd0, 3'd7, 3'd3, 3'd1, 3'd5};
    localparam logic [2:0]  V_RB [NV] = '{3'd1, 3'd2, 3'd0, 3'd7, 3'd4};
    localparam logic [8:0]  V_IM [NV] = '{9'h004, 9'h1FC, 9'h0FC, 9'h100, 9'h000};
    localparam logic [31:0] V_BA [NV] = '{32'h0000_1000, 32'h0000_2000, 32'h0000_0100,
                                         32'h8000_0000, 32'h0000_4440};
    localparam logic [31:0] V_EA [NV] = '{32'h0000_1004, 32'h0000_1FFC, 32'h0000_01FC,
                                         32'h7FFF_FF00, 32'h0000_4440};
    localparam logic [31:0] V_RD [NV] = '{32'hDEAD_BEEF, 32'h1234_5678, 32'h0000_0001,
                                         32'hFFFF_FFFF, 32'hA5A5_5A5A};

    task automatic do_ll(input logic [2:0] rx, input logic [2:0] rb, input logic [8:0] imm,
                         input logic [31:0] base, input logic [31:0] exp_ea,
                         input logic [31:0] rd, input int stall);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = enc(rx, rb, imm); base_val = base;
        #1 chk("R2 base_idx", base_idx, mapr(rb));
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R5 mem_req", mem_req, 1);
        chk("R3 mem_addr", mem_addr, exp_ea);
        chk("R5 instr_ready low", instr_ready, 0);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk("R5 req held", mem_req, 1);
            chk("R5 addr held", mem_addr, exp_ea);
            chk("R6 no early wb", wb_en, 0);
        end
        mem_ack = 1'b1; mem_rdata = rd;
        #1;
        chk("R6 wb_en", wb_en, 1);
        chk("R6 wb_data", wb_data, rd);
        chk("R6 wb_idx", wb_idx, mapr(rx));
        @(negedge clk);
        mem_ack = 1'b0; link_clr = 1'b0;
        chk("R7 link_flag", link_flag, 1);
        chk("R7 link_addr", link_addr, exp_ea);
        chk("R5 req dropped", mem_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("reset mem_req", mem_req, 0);
        chk("reset link_flag", link_flag, 0);
        chk("reset instr_ready", instr_ready, 1);
        chk("reset addr_err", addr_err, 0);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R6 R7
        for (int i = 0; i < NV; i++)
            do_ll(V_RX[i], V_RB[i], V_IM[i], V_BA[i], V_EA[i], V_RD[i], i % 3);

        // R4: misaligned address, link state kept
        @(negedge clk);
        instr_valid = 1'b1; instr_word = enc(3'd2, 3'd3, 9'h001); base_val = 32'h0000_9000;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R4 addr_err", addr_err, 1);
        chk("R4 no mem_req", mem_req, 0);
        chk("R4 no wb", wb_en, 0);
        @(negedge clk);
        chk("R4 pulse ends", addr_err, 0);
        chk("R4 flag kept", link_flag, 1);
        chk("R4 addr kept", link_addr, 32'h0000_4440);

        // R1: wrong sub-select and nonzero reserved field ignored
        @(negedge clk);
        instr_valid = 1'b1; instr_word = enc(3'd2, 3'd3, 9'h0) & ~32'h0000_0040;
        @(negedge clk);
        instr_word = enc(3'd2, 3'd3, 9'h0) | 32'h0200_0000;
        chk("R1 sel ignored req", mem_req, 0);
        chk("R1 sel ignored err", addr_err, 0);
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R1 rsv ignored req", mem_req, 0);
        chk("R1 rsv ignored ready", instr_ready, 1);

        // R9: query mismatch fails and clears
        @(negedge clk);
        sc_query = 1'b1; sc_addr = 32'h0000_4444;
        #1 chk("R9 mismatch sc_ok", sc_ok, 0);
        @(negedge clk);
        sc_query = 1'b0;
        chk("R9 cleared after fail", link_flag, 0);

        // R7: re-arm replaces; R9 match succeeds then clears
        do_ll(3'd4, 3'd5, 9'h010, 32'h0000_0300, 32'h0000_0310, 32'h0BAD_F00D, 0);
        do_ll(3'd6, 3'd5, 9'h020, 32'h0000_0300, 32'h0000_0320, 32'h0000_0042, 1);
        @(negedge clk);
        sc_query = 1'b1; sc_addr = 32'h0000_0310;
        #1 chk("R7 old addr replaced", sc_ok, 0);
        @(negedge clk);
        sc_query = 1'b0;
        do_ll(3'd6, 3'd5, 9'h020, 32'h0000_0300, 32'h0000_0320, 32'h0000_0042, 0);
        @(negedge clk);
        sc_query = 1'b1; sc_addr = 32'h0000_0320;
        #1 chk("R9 match sc_ok", sc_ok, 1);
        @(negedge clk);
        sc_query = 1'b0;
        chk("R9 cleared after success", link_flag, 0);
        @(negedge clk);
        sc_query = 1'b1;
        #1 chk("R9 second query fails", sc_ok, 0);
        @(negedge clk);
        sc_query = 1'b0;

        // R8: external clear, and arm beats clear in the same cycle
        do_ll(3'd2, 3'd2, 9'h000, 32'h0000_0800, 32'h0000_0800, 32'h1, 0);
        @(negedge clk);
        link_clr = 1'b1;
        @(negedge clk);
        link_clr = 1'b0;
        chk("R8 clear", link_flag, 0);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = enc(3'd3, 3'd3, 9'h008); base_val = 32'h0000_0A00;
        @(negedge clk);
        instr_valid = 1'b0;
        mem_ack = 1'b1; link_clr = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0; link_clr = 1'b0;
        chk("R8 arm wins flag", link_flag, 1);
        chk("R8 arm wins addr", link_addr, 32'h0000_0A08);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule